// File: doc/BRIEF.md
# DRAM Start-Up Strobe Sequencer

This block sits between a memory controller and an asynchronous EDO DRAM. It takes the DRAM through its mandatory power-up procedure. After reset it waits a fixed settling time. It then drives a burst of warm-up refresh cycles on the active-low row and column strobes. Only after that burst does it raise `ready` and start passing access grants to the controller. While the settling time runs, it can optionally pulse the row strobe with dummy RAS-only cycles. A compile-time switch selects the warm-up flavour: either RAS-only cycles or cycles with the column strobe falling first.

After `ready` is raised, an idle monitor watches every row-strobe falling edge. That covers the block's own edges and the ones the controller reports on `acc_ras_fall`. If no such edge arrives within the idle limit, the block drops `ready`, replays the full warm-up burst and then grants access again.

All timings are given as parameters in physical units (microseconds or nanoseconds) and converted to clock cycles from `CLK_HZ`. Every conversion rounds up and gives at least one cycle.

Top module: `dinit_seq`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the next clock gives `ras_n`=1, `cas_n`=1, `ready`=0 and `acc_gnt`=0, and the settling wait starts over.
- R2: `ready` stays 0 for at least the wait time, WAIT_CYC clock cycles, after `rst` is released.
- R3: Between the end of the wait and the rise of `ready`, exactly N_WARM warm-up cycles are issued. When `ready` rises, both strobes are high.
- R4: With USE_CBR=1, each warm-up cycle pulls `cas_n` low exactly CAS_LEAD cycles before `ras_n` falls, and `cas_n` stays low while `ras_n` is low. With USE_CBR=0, `cas_n` stays 1 at all times.
- R5: With DUMMY_EN=1, one or more RAS-only pulses (with `cas_n`=1) occur during the wait. With DUMMY_EN=0, `ras_n` does not fall before the wait ends.
- R6: Each `ras_n` low pulse lasts exactly RAS_LOW cycles. Between pulses `ras_n` stays high for at least PRECHG cycles. `cas_n` never rises while `ras_n` is low.
- R7: `acc_gnt` = `acc_req` AND `ready` in the same cycle. A request held high while `ready` is 0 is granted in the first cycle `ready` is 1.
- R8: If no row-strobe falling edge (internal, or reported on `acc_ras_fall`) occurs for IDLE_CYC cycles while `ready` is 1, `ready` falls on the next cycle. Exactly N_WARM warm-up cycles then follow before `ready` returns to 1.
- R9: `acc_ras_fall` pulses spaced less than IDLE_CYC cycles apart keep `ready` at 1 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Controller asks for an access slot |
| acc_ras_fall | input | 1 | One-cycle strobe: the controller dropped RAS for a normal access |
| acc_gnt | output | 1 | Access granted (request while ready) |
| ready | output | 1 | Device initialised and usable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |

## Verification
The strobes come from registers: a strobe changes at the clock edge that follows the decision to change it. The bench therefore measures pulse widths, column lead and gaps by counting consecutive falling-edge samples of the strobe pins. It does not predict exact edge times. `acc_gnt` is combinational, so it is compared in the very cycle its inputs are sampled. `ready` falls one cycle after the idle count reaches its limit. After the last reported RAS edge, the bench allows a window of IDLE_CYC to IDLE_CYC+2 samples for that fall. Ready-after-reset is checked against a lower bound of the wait time and an upper bound that includes the warm-up burst and any dummy pulse still in flight.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

    typedef enum logic [1:0] {
        SQ_WAIT,
        SQ_WARM,
        SQ_READY
    } seq_state_e;

    typedef enum logic [1:0] {
        SG_IDLE,
        SG_LEAD,
        SG_LOW,
        SG_PRE
    } sg_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ras_n: 1'b1, cas_n: 1'b1};

    // ceiling of time * frequency, at least one cycle
    function automatic int span_to_cyc(longint hz, longint amount, longint per_sec);
        longint c;
        c = (hz * amount + per_sec - 1) / per_sec;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int ns_to_cyc(longint hz, longint ns);
        return span_to_cyc(hz, ns, 64'd1_000_000_000);
    endfunction

    function automatic int us_to_cyc(longint hz, longint us);
        return span_to_cyc(hz, us, 64'd1_000_000);
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dinit_strobe_gen.sv
module dinit_strobe_gen
    import dinit_pkg::*;
#(
    parameter int LOW_CYC  = 3,
    parameter int LEAD_CYC = 1,
    parameter int PRE_CYC  = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    cbr,
    output strobe_t pins,
    output logic    idle,
    output logic    fall
);
    localparam int MAXC = max3(LOW_CYC, LEAD_CYC, PRE_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t LOW_LD  = cnt_t'(LOW_CYC - 1);
    localparam cnt_t LEAD_LD = cnt_t'(LEAD_CYC - 1);
    localparam cnt_t PRE_LD  = cnt_t'(PRE_CYC - 1);

    sg_phase_e ph;
    cnt_t      cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= SG_IDLE;
            cnt  <= '0;
            pins <= STROBE_REST;
            fall <= 1'b0;
        end else begin
            fall <= 1'b0;
            case (ph)
                SG_IDLE: begin
                    if (start) begin
                        if (cbr) begin
                            ph         <= SG_LEAD;
                            cnt        <= LEAD_LD;
                            pins.cas_n <= 1'b0;
                        end else begin
                            ph         <= SG_LOW;
                            cnt        <= LOW_LD;
                            pins.ras_n <= 1'b0;
                            fall       <= 1'b1;
                        end
                    end
                end
                SG_LEAD: begin
                    if (cnt == '0) begin
                        ph         <= SG_LOW;
                        cnt        <= LOW_LD;
                        pins.ras_n <= 1'b0;
                        fall       <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SG_LOW: begin
                    if (cnt == '0) begin
                        ph   <= SG_PRE;
                        cnt  <= PRE_LD;
                        pins <= STROBE_REST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SG_PRE: begin
                    if (cnt == '0) ph <= SG_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: ph <= SG_IDLE;
            endcase
        end
    end

    assign idle = (ph == SG_IDLE);

endmodule

// File: rtl/dinit_idle_mon.sv
module dinit_idle_mon #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_int,
    input  logic fall_ext,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t LIM = cnt_t'(LIMIT);

    cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst || fall_int || fall_ext) cnt <= '0;
        else if (cnt != LIM)             cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);

endmodule

// File: rtl/dinit_seq.sv
module dinit_seq
    import dinit_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int WAIT_US     = 500,
    parameter int IDLE_US     = 64_000,
    parameter int RAS_LOW_NS  = 50,
    parameter int CAS_LEAD_NS = 10,
    parameter int PRECHG_NS   = 30,
    parameter int N_WARM      = 8,
    parameter bit USE_CBR     = 1'b1,
    parameter bit DUMMY_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_req,
    input  logic acc_ras_fall,
    output logic acc_gnt,
    output logic ready,
    output logic ras_n,
    output logic cas_n
);
    localparam int WAIT_CYC = us_to_cyc(CLK_HZ, WAIT_US);
    localparam int IDLE_CYC = us_to_cyc(CLK_HZ, IDLE_US);
    localparam int LOW_CYC  = ns_to_cyc(CLK_HZ, RAS_LOW_NS);
    localparam int LEAD_CYC = ns_to_cyc(CLK_HZ, CAS_LEAD_NS);
    localparam int PRE_CYC  = ns_to_cyc(CLK_HZ, PRECHG_NS);
    localparam int WW       = $clog2(WAIT_CYC + 1);
    localparam int NW       = $clog2(N_WARM + 1);
    typedef logic [WW-1:0] wait_t;
    typedef logic [NW-1:0] warm_t;
    localparam wait_t WAIT_LAST = wait_t'(WAIT_CYC - 1);
    localparam warm_t WARM_ALL  = warm_t'(N_WARM);

    seq_state_e st;
    wait_t      wait_cnt;
    warm_t      issued;
    strobe_t    pins;
    logic       sg_idle, sg_fall, sg_start, sg_cbr;
    logic       start_warm, start_dummy, idle_exp;

    assign start_warm = (st == SQ_WARM) && sg_idle && (issued != WARM_ALL);

    generate
        if (DUMMY_EN) begin : g_dummy
            assign start_dummy = (st == SQ_WAIT) && sg_idle;
        end else begin : g_no_dummy
            assign start_dummy = 1'b0;
        end
        if (USE_CBR) begin : g_cbr
            assign sg_cbr = (st == SQ_WARM);
        end else begin : g_ras_only
            assign sg_cbr = 1'b0;
        end
    endgenerate

    assign sg_start = start_warm || start_dummy;

    dinit_strobe_gen #(
        .LOW_CYC (LOW_CYC),
        .LEAD_CYC(LEAD_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_strobe (
        .clk  (clk),
        .rst  (rst),
        .start(sg_start),
        .cbr  (sg_cbr),
        .pins (pins),
        .idle (sg_idle),
        .fall (sg_fall)
    );

    dinit_idle_mon #(
        .LIMIT(IDLE_CYC)
    ) u_idle (
        .clk     (clk),
        .rst     (rst),
        .fall_int(sg_fall),
        .fall_ext(acc_ras_fall),
        .expired (idle_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_WAIT;
            wait_cnt <= '0;
            issued   <= '0;
        end else begin
            case (st)
                SQ_WAIT: begin
                    if (wait_cnt == WAIT_LAST) begin
                        st     <= SQ_WARM;
                        issued <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                SQ_WARM: begin
                    if (start_warm) issued <= issued + 1'b1;
                    else if (issued == WARM_ALL && sg_idle) st <= SQ_READY;
                end
                SQ_READY: begin
                    if (idle_exp) begin
                        st     <= SQ_WARM;
                        issued <= '0;
                    end
                end
                default: st <= SQ_WAIT;
            endcase
        end
    end

    assign ready   = (st == SQ_READY);
    assign acc_gnt = acc_req && ready;
    assign ras_n   = pins.ras_n;
    assign cas_n   = pins.cas_n;

endmodule

// File: rtl/dinit_seq_chk.sv
module dinit_seq_chk #(
    parameter int IDLE_CYC = 1,
    parameter bit USE_CBR  = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic acc_req,
    input logic acc_ras_fall,
    input logic acc_gnt,
    input logic ready,
    input logic ras_n,
    input logic cas_n
);
    logic prev_ras;
    int   quiet;
    logic saw_fall;

    assign saw_fall = prev_ras && !ras_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ras <= 1'b1;
            quiet    <= 0;
        end else begin
            prev_ras <= ras_n;
            if (saw_fall || acc_ras_fall) quiet <= 0;
            else if (quiet < IDLE_CYC + 2) quiet <= quiet + 1;
        end
    end

    // R1
    a_r1_reset_rest: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && !ready));

    // R7
    a_r7_grant_gated: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |-> (ready && acc_req));

    // R3
    a_r3_rest_at_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (ras_n && cas_n));

    // R6
    a_r6_cas_not_alone: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> ras_n);

    // R8
    a_r8_idle_bound: assert property (@(posedge clk) disable iff (rst)
        ready |-> (quiet <= IDLE_CYC + 1));

    generate
        if (USE_CBR) begin : g_cbr
            // R4
            a_r4_cas_leads: assert property (@(posedge clk) disable iff (rst)
                ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
        end else begin : g_ras_only
            // R4
            a_r4_cas_idle: assert property (@(posedge clk) disable iff (rst)
                cas_n);
        end
    endgenerate

endmodule

bind dinit_seq dinit_seq_chk #(
    .IDLE_CYC(IDLE_CYC),
    .USE_CBR (USE_CBR)
) u_chk (.*);

// File: tb/tb_dinit_seq.sv
module tb_dinit_seq;

    localparam int E_WAIT = 500;
    localparam int E_IDLE = 3000;
    localparam int E_RAS  = 4;
    localparam int E_LEAD = 2;
    localparam int E_PRE  = 3;
    localparam int E_NW   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic xfall = 1'b0;
    logic [1:0] ras_v, cas_v, rdy_v, gnt_v;

    always #10 clk = ~clk;

    dinit_seq #(
        .CLK_HZ(1_000_000), .WAIT_US(500), .IDLE_US(3000),
        .RAS_LOW_NS(4000), .CAS_LEAD_NS(2000), .PRECHG_NS(3000),
        .N_WARM(8), .USE_CBR(1'b1), .DUMMY_EN(1'b1)
    ) dut (
        .clk(clk), .rst(rst), .acc_req(req), .acc_ras_fall(xfall),
        .acc_gnt(gnt_v[0]), .ready(rdy_v[0]), .ras_n(ras_v[0]), .cas_n(cas_v[0])
    );

    dinit_seq #(
        .CLK_HZ(1_000_000), .WAIT_US(500), .IDLE_US(3000),
        .RAS_LOW_NS(4000), .CAS_LEAD_NS(2000), .PRECHG_NS(3000),
        .N_WARM(8), .USE_CBR(1'b0), .DUMMY_EN(1'b0)
    ) dut_b (
        .clk(clk), .rst(rst), .acc_req(req), .acc_ras_fall(xfall),
        .acc_gnt(gnt_v[1]), .ready(rdy_v[1]), .ras_n(ras_v[1]), .cas_n(cas_v[1])
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int rel = 0;
    int low_len[2], high_len[2], cas_low[2], cbr_f[2], plain_f[2], first_fall[2];
    bit prev_r[2], seen_fall[2];
    bit b_cas_bad = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_gnt(input logic r, input logic rd);
        return r && rd;
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 2; i++) begin
            cbr_f[i] = 0;
            plain_f[i] = 0;
            first_fall[i] = -1;
        end
    endtask

    // pin monitor: widths, leads, fall classification, grant rule
    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                prev_r[i] = 1'b1;
                seen_fall[i] = 1'b0;
                low_len[i] = 0;
                high_len[i] = 0;
                cas_low[i] = 0;
            end else begin
                chk(gnt_v[i] === exp_gnt(req, rdy_v[i]), "R7 grant", int'(gnt_v[i]),
                    int'(exp_gnt(req, rdy_v[i])));
                if (prev_r[i] && !ras_v[i]) begin
                    if (seen_fall[i])
                        chk(high_len[i] >= E_PRE, "R6 precharge gap", high_len[i], E_PRE);
                    if (!cas_v[i]) begin
                        cbr_f[i]++;
                        chk(cas_low[i] == E_LEAD, "R4 cas lead", cas_low[i], E_LEAD);
                    end else begin
                        plain_f[i]++;
                    end
                    if (first_fall[i] < 0) first_fall[i] = cyc - rel;
                    seen_fall[i] = 1'b1;
                    low_len[i] = 1;
                end else if (!ras_v[i]) begin
                    low_len[i]++;
                end
                if (!prev_r[i] && ras_v[i]) begin
                    chk(low_len[i] == E_RAS, "R6 ras low width", low_len[i], E_RAS);
                    high_len[i] = 1;
                end else if (ras_v[i]) begin
                    high_len[i]++;
                end
                if (!cas_v[i]) cas_low[i]++;
                else           cas_low[i] = 0;
                if (i == 1 && !cas_v[i]) b_cas_bad = 1'b1;
                prev_r[i] = ras_v[i];
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int rdy_at[2];
        int warm_n[2];
        int pre_plain;
        int drop_at[2];
        bit held;
        void'($urandom(32'd1234));
        clear_counts();

        // R1: reset state
        repeat (3) step();
        req = 1'b1;
        step();
        for (int i = 0; i < 2; i++) begin
            chk(ras_v[i] && cas_v[i], "R1 strobes high in reset", int'(ras_v[i] & cas_v[i]), 1);
            chk(!rdy_v[i] && !gnt_v[i], "R1 ready/grant low in reset", int'(rdy_v[i] | gnt_v[i]), 0);
        end

        // release and track start-up
        rst = 1'b0;
        rel = cyc;
        clear_counts();
        rdy_at[0] = -1;
        rdy_at[1] = -1;
        pre_plain = 0;
        for (int k = 0; k < 2000; k++) begin
            req = 1'($urandom % 2);
            step();
            for (int i = 0; i < 2; i++) begin
                if (rdy_v[i] && rdy_at[i] < 0) begin
                    rdy_at[i] = cyc - rel;
                    warm_n[i] = (i == 0) ? cbr_f[0] : plain_f[1];
                    if (i == 0) pre_plain = plain_f[0];
                end
            end
            if (rdy_at[0] >= 0 && rdy_at[1] >= 0) break;
        end
        for (int i = 0; i < 2; i++) begin
            chk(rdy_at[i] > E_WAIT, "R2 ready after wait", rdy_at[i], E_WAIT + 1);
            chk(rdy_at[i] <= E_WAIT + E_NW * (E_LEAD + E_RAS + E_PRE + 2) + 12,
                "R2 ready not late", rdy_at[i], E_WAIT + 100);
            chk(warm_n[i] == E_NW, "R3 warm-up count", warm_n[i], E_NW);
        end
        chk(pre_plain > 0, "R5 dummy pulses during wait", pre_plain, 1);
        chk(first_fall[1] >= E_WAIT, "R5 no ras fall in wait when disabled", first_fall[1], E_WAIT);

        // R9: reported edges keep ready up
        held = 1'b1;
        for (int b = 0; b < 6; b++) begin
            int gap;
            gap = 100 + int'($urandom % 1500);
            for (int k = 0; k < gap; k++) begin
                req = 1'($urandom % 2);
                step();
                if (!rdy_v[0] || !rdy_v[1]) held = 1'b0;
            end
            xfall = 1'b1;
            step();
            xfall = 1'b0;
        end
        chk(held, "R9 ready held by access edges", int'(held), 1);

        // R8: go quiet, expect drop then replayed warm-up; R7 held request
        req = 1'b1;
        drop_at[0] = -1;
        drop_at[1] = -1;
        for (int k = 1; k <= E_IDLE + 50; k++) begin
            step();
            for (int i = 0; i < 2; i++)
                if (!rdy_v[i] && drop_at[i] < 0) drop_at[i] = k;
            if (drop_at[0] >= 0 && drop_at[1] >= 0) break;
        end
        for (int i = 0; i < 2; i++)
            chk(drop_at[i] >= E_IDLE && drop_at[i] <= E_IDLE + 2, "R8 idle drop time",
                drop_at[i], E_IDLE + 1);
        clear_counts();
        rdy_at[0] = -1;
        rdy_at[1] = -1;
        for (int k = 0; k < 400; k++) begin
            step();
            for (int i = 0; i < 2; i++) begin
                if (rdy_v[i] && rdy_at[i] < 0) begin
                    rdy_at[i] = k;
                    warm_n[i] = (i == 0) ? cbr_f[0] : plain_f[1];
                    chk(gnt_v[i] == 1'b1, "R7 held request granted", int'(gnt_v[i]), 1);
                end
            end
            if (rdy_at[0] >= 0 && rdy_at[1] >= 0) break;
        end
        for (int i = 0; i < 2; i++) begin
            chk(rdy_at[i] >= 0, "R8 ready returns", rdy_at[i], 1);
            chk(warm_n[i] == E_NW, "R8 replayed warm-up count", warm_n[i], E_NW);
        end

        // random traffic then reset mid-operation
        for (int k = 0; k < 300; k++) begin
            req = 1'($urandom % 2);
            xfall = ($urandom % 50) == 0;
            step();
        end
        xfall = 1'b0;
        rst = 1'b1;
        req = 1'b1;
        step();
        step();
        for (int i = 0; i < 2; i++) begin
            chk(ras_v[i] && cas_v[i], "R1 strobes high after late reset", int'(ras_v[i] & cas_v[i]), 1);
            chk(!rdy_v[i] && !gnt_v[i], "R1 ready low after late reset", int'(rdy_v[i] | gnt_v[i]), 0);
        end
        rst = 1'b0;
        step();
        chk(!b_cas_bad, "R4 cas idle in ras-only mode", int'(b_cas_bad), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule